// File: doc/BRIEF.md
# Rail Supervisor Fault Aggregator

This block watches the telemetry of a set of supply channels and turns it into three active-low status lines for the rest of the chip. Each channel delivers voltage and current sample codes, strobed by a per-channel valid bit. Each channel also has its own set of limit codes: four voltage thresholds and three signed current thresholds. Every sample of a monitored channel is compared against these windows. Each hit sets a sticky per-channel flag.

A channel is brought up by an on-request pulse. It then has a bounded ramp window in which it must reach its undervoltage fault limit. A fault, or a missed ramp window, trips the channel off. The general alert line reports any sticky flag. These flags are released only by a clear pulse, and only when the condition behind a flag has gone away. The auxiliary fault line reports only severe over/under conditions and is released only when the channel is requested on again. The faulted-off line reports any tripped channel.

Each channel runs a four-state machine:
- `CH_OFF` is the reset state. On `on_req` it takes the start transition to `CH_RAMP`.
- `CH_RAMP` takes the ramp-done transition to `CH_ON` on a clean sample at or above the undervoltage fault limit.
- `CH_RAMP` takes the trip transition to `CH_TRIP` on a trip-class fault or on ramp timeout.
- `CH_ON` takes the trip transition to `CH_TRIP` on a trip-class fault.
- `CH_TRIP` takes the restart transition to `CH_RAMP` on `on_req`.

Top module: `rail_fault_agg`

## Requirements
- R1: After reset all channels are off, every sticky flag is 0, and `alert_n`, `auxflt_n` and `fltoff_n` are all 1.
- R2: The voltage flags are set from unsigned compares, with flag byte bit positions as follows. Bit0 (UV fault) is set when V < undervoltage fault limit. Bit1 (UV warning) is set when V < undervoltage warning limit. Bit2 (OV warning) is set when V > overvoltage warning limit. Bit3 (OV fault) is set when V > overvoltage fault limit. Channel c owns bits [8c+7:8c] of `flags`.
- R3: The current flags are set from two's-complement signed compares. Bit4 (OC warning) is set when I > overcurrent warning limit. Bit5 (OC fault) is set when I > overcurrent fault limit. Bit6 (UC fault) is set when I < undercurrent fault limit, which may be negative.
- R4: A flag set by a sample becomes visible the cycle after that sample's clock edge. It stays set until a clear. `alert_n` is 0 whenever any flag of any channel is set.
- R5: A `clr_faults` pulse leaves a flag set if the last sample taken by a still-monitored channel still showed that condition.
- R6: `auxflt_n` goes 0 only for OV fault, OC fault or UC fault. It stays 0 through clears. It returns to 1 when that channel receives `on_req` while tripped.
- R7: UV fault, OV fault, OC fault, UC fault or ramp timeout moves the channel to `CH_TRIP`. `fltoff_n` is 0 while any channel is tripped. Clears do not release a trip.
- R8: In `CH_RAMP` the UV fault and UV warning compares are masked. If no clean sample at or above the UV fault limit arrives within `TON_CYC` cycles of `on_req`, bit7 (ramp timeout) is set and the channel trips on the `TON_CYC`-th edge after the request.
- R9: Samples presented to a channel in `CH_OFF` or `CH_TRIP` set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | NCH | Per-channel sample strobe |
| volt_smp | input | NCH*VW | Voltage codes, channel c at [c*VW +: VW] |
| curr_smp | input | NCH*IW | Signed current codes, channel c at [c*IW +: IW] |
| lim_vuf | input | NCH*VW | Undervoltage fault limits |
| lim_vuw | input | NCH*VW | Undervoltage warning limits |
| lim_vow | input | NCH*VW | Overvoltage warning limits |
| lim_vof | input | NCH*VW | Overvoltage fault limits |
| lim_iuf | input | NCH*IW | Signed undercurrent fault limits |
| lim_iow | input | NCH*IW | Signed overcurrent warning limits |
| lim_iof | input | NCH*IW | Signed overcurrent fault limits |
| clr_faults | input | 1 | Clear-faults pulse |
| on_req | input | NCH | Per-channel on-request pulses |
| alert_n | output | 1 | Active-low general alert |
| auxflt_n | output | 1 | Active-low severe-fault line |
| fltoff_n | output | 1 | Active-low any-channel-tripped line |
| flags | output | NCH*8 | Sticky per-channel flag bytes |

## Verification
The bench issues a clear while a warning is still present in the last sample. A design that ignored the condition would drop the alert early. It then clears after a severe fault and checks that the auxiliary line stays low while the alert releases. A design sharing one release path would free both together. A current below a negative undercurrent limit must trip the channel, while a small negative current must not; an unsigned compare would get one of these wrong. The ramp timeout is sampled one edge before and on the expected edge, which exposes an off-by-one counter. Samples sent to tripped channels must leave the flags untouched.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
    typedef enum logic [1:0] {
        CH_OFF,
        CH_RAMP,
        CH_ON,
        CH_TRIP
    } ch_state_e;

    localparam int NFLAG  = 8;
    localparam int FL_UVF = 0;
    localparam int FL_UVW = 1;
    localparam int FL_OVW = 2;
    localparam int FL_OVF = 3;
    localparam int FL_OCW = 4;
    localparam int FL_OCF = 5;
    localparam int FL_UCF = 6;
    localparam int FL_TMO = 7;

    // flags that switch a channel off
    localparam logic [NFLAG-1:0] TRIP_MASK = 8'h69;
    // flags that drive the auxiliary line
    localparam logic [NFLAG-1:0] AUX_MASK  = 8'h68;
    // compares observed while ramping (undervoltage masked)
    localparam logic [NFLAG-1:0] RAMP_MON  = 8'h7C;
    // compares observed while on
    localparam logic [NFLAG-1:0] ON_MON    = 8'h7F;
endpackage

// File: rtl/rfa_window_cmp.sv
module rfa_window_cmp
    import rfa_pkg::*;
#(
    parameter int VW = 16,
    parameter int IW = 16
) (
    input  logic [VW-1:0]        volt,
    input  logic signed [IW-1:0] curr,
    input  logic [VW-1:0]        vuf,
    input  logic [VW-1:0]        vuw,
    input  logic [VW-1:0]        vow,
    input  logic [VW-1:0]        vof,
    input  logic signed [IW-1:0] iuf,
    input  logic signed [IW-1:0] iow,
    input  logic signed [IW-1:0] iof,
    output logic [NFLAG-1:0]     raw
);
    always_comb begin
        raw         = '0;
        raw[FL_UVF] = volt < vuf;
        raw[FL_UVW] = volt < vuw;
        raw[FL_OVW] = volt > vow;
        raw[FL_OVF] = volt > vof;
        raw[FL_OCW] = curr > iow;
        raw[FL_OCF] = curr > iof;
        raw[FL_UCF] = curr < iuf;
    end
endmodule

// File: rtl/rfa_chan.sv
module rfa_chan
    import rfa_pkg::*;
#(
    parameter int VW      = 16,
    parameter int IW      = 16,
    parameter int TON_CYC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_vld,
    input  logic [VW-1:0]        volt,
    input  logic signed [IW-1:0] curr,
    input  logic [VW-1:0]        vuf,
    input  logic [VW-1:0]        vuw,
    input  logic [VW-1:0]        vow,
    input  logic [VW-1:0]        vof,
    input  logic signed [IW-1:0] iuf,
    input  logic signed [IW-1:0] iow,
    input  logic signed [IW-1:0] iof,
    input  logic                 clr,
    input  logic                 on_req,
    output logic [NFLAG-1:0]     flags_q,
    output logic                 aux_q,
    output logic                 tripped
);
    localparam int CW = $clog2(TON_CYC + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(TON_CYC - 1);

    ch_state_e        st, st_nxt;
    logic [CW-1:0]    cnt;
    logic [NFLAG-1:0] raw, mon_mask, hit_now, set_vec, cond_q, clr_vec;
    logic             trip_hit, ramp_ok, tmo_evt, monitored_nxt;

    rfa_window_cmp #(.VW(VW), .IW(IW)) u_cmp (
        .volt(volt), .curr(curr),
        .vuf(vuf), .vuw(vuw), .vow(vow), .vof(vof),
        .iuf(iuf), .iow(iow), .iof(iof),
        .raw(raw)
    );

    always_comb begin
        unique case (st)
            CH_ON:   mon_mask = ON_MON;
            CH_RAMP: mon_mask = RAMP_MON;
            default: mon_mask = '0;
        endcase
    end

    assign hit_now  = smp_vld ? (raw & mon_mask) : '0;
    assign trip_hit = |(hit_now & TRIP_MASK);
    assign ramp_ok  = smp_vld && !raw[FL_UVF] && !trip_hit;
    assign tmo_evt  = (st == CH_RAMP) && !ramp_ok && !trip_hit && (cnt == CNT_LAST);

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            CH_OFF:  if (on_req) st_nxt = CH_RAMP;
            CH_RAMP: begin
                if (trip_hit)     st_nxt = CH_TRIP;
                else if (ramp_ok) st_nxt = CH_ON;
                else if (tmo_evt) st_nxt = CH_TRIP;
            end
            CH_ON:   if (trip_hit) st_nxt = CH_TRIP;
            CH_TRIP: if (on_req) st_nxt = CH_RAMP;
            default: st_nxt = CH_OFF;
        endcase
    end

    // state register and ramp timer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= CH_OFF;
            cnt <= '0;
        end else begin
            st <= st_nxt;
            if (st != CH_RAMP)
                cnt <= '0;
            else if (cnt != CNT_LAST)
                cnt <= cnt + 1'b1;
        end
    end

    assign monitored_nxt = (st_nxt == CH_ON) || (st_nxt == CH_RAMP);
    assign set_vec       = hit_now | (tmo_evt ? (NFLAG'(1) << FL_TMO) : '0);
    assign clr_vec       = clr ? ~cond_q : '0;

    // output latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            cond_q  <= '0;
            aux_q   <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~clr_vec) | set_vec;
            if (!monitored_nxt)
                cond_q <= '0;
            else if (smp_vld)
                cond_q <= hit_now;
            if (on_req && st == CH_TRIP)
                aux_q <= 1'b0;
            else if (|(hit_now & AUX_MASK))
                aux_q <= 1'b1;
        end
    end

    assign tripped = (st == CH_TRIP);

    assert_trip_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_TRIP && !on_req) |=> (st == CH_TRIP));
    assert_aux_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_q && !on_req) |=> aux_q);
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> (($past(flags_q) & ~flags_q) == '0));
    assert_ramp_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_RAMP) |-> (cnt < CW'(TON_CYC)));
    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == CH_OFF && !clr) |=> $stable(flags_q));
endmodule

// File: rtl/rail_fault_agg.sv
module rail_fault_agg
    import rfa_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int VW      = 16,
    parameter int IW      = 16,
    parameter int TON_CYC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       smp_vld,
    input  logic [NCH*VW-1:0]    volt_smp,
    input  logic [NCH*IW-1:0]    curr_smp,
    input  logic [NCH*VW-1:0]    lim_vuf,
    input  logic [NCH*VW-1:0]    lim_vuw,
    input  logic [NCH*VW-1:0]    lim_vow,
    input  logic [NCH*VW-1:0]    lim_vof,
    input  logic [NCH*IW-1:0]    lim_iuf,
    input  logic [NCH*IW-1:0]    lim_iow,
    input  logic [NCH*IW-1:0]    lim_iof,
    input  logic                 clr_faults,
    input  logic [NCH-1:0]       on_req,
    output logic                 alert_n,
    output logic                 auxflt_n,
    output logic                 fltoff_n,
    output logic [NCH*NFLAG-1:0] flags
);
    logic [NCH-1:0] aux_v, trip_v;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        rfa_chan #(.VW(VW), .IW(IW), .TON_CYC(TON_CYC)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .smp_vld(smp_vld[c]),
            .volt(volt_smp[c*VW +: VW]),
            .curr(curr_smp[c*IW +: IW]),
            .vuf(lim_vuf[c*VW +: VW]), .vuw(lim_vuw[c*VW +: VW]),
            .vow(lim_vow[c*VW +: VW]), .vof(lim_vof[c*VW +: VW]),
            .iuf(lim_iuf[c*IW +: IW]), .iow(lim_iow[c*IW +: IW]),
            .iof(lim_iof[c*IW +: IW]),
            .clr(clr_faults), .on_req(on_req[c]),
            .flags_q(flags[c*NFLAG +: NFLAG]),
            .aux_q(aux_v[c]),
            .tripped(trip_v[c])
        );
    end

    assign alert_n  = ~|flags;
    assign auxflt_n = ~|aux_v;
    assign fltoff_n = ~|trip_v;

    assert_aux_implies_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !auxflt_n |-> !fltoff_n);
endmodule

// File: tb/sim_rail_fault_agg.sv
module sim_rail_fault_agg;
    localparam int NCH = 4, VW = 16, IW = 16, TON = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NCH-1:0]    smp_vld = '0, on_req = '0;
    logic [NCH*VW-1:0] volt_smp = '0, lim_vuf, lim_vuw, lim_vow, lim_vof;
    logic [NCH*IW-1:0] curr_smp = '0, lim_iuf, lim_iow, lim_iof;
    logic              clr_faults = 1'b0;
    logic              alert_n, auxflt_n, fltoff_n;
    logic [NCH*8-1:0]  flags;

    always #5 clk = ~clk;

    rail_fault_agg #(.NCH(NCH), .VW(VW), .IW(IW), .TON_CYC(TON)) u0 (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .volt_smp(volt_smp),
        .curr_smp(curr_smp), .lim_vuf(lim_vuf), .lim_vuw(lim_vuw),
        .lim_vow(lim_vow), .lim_vof(lim_vof), .lim_iuf(lim_iuf),
        .lim_iow(lim_iow), .lim_iof(lim_iof), .clr_faults(clr_faults),
        .on_req(on_req), .alert_n(alert_n), .auxflt_n(auxflt_n),
        .fltoff_n(fltoff_n), .flags(flags)
    );

    typedef struct {
        int          due;
        logic [31:0] fl;
        logic        al, ax, fo;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          cyc = 0, n_run = 0, n_fail = 0;
    logic [31:0] e_flags = '0;
    logic [3:0]  e_aux = '0, e_trip = '0;
    bit          done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            n_run++;
            if (flags !== e.fl || alert_n !== e.al || auxflt_n !== e.ax || fltoff_n !== e.fo) begin
                n_fail++;
                $display("FAIL %s: got flags=%h al=%b ax=%b fo=%b exp flags=%h al=%b ax=%b fo=%b",
                         e.tag, flags, alert_n, auxflt_n, fltoff_n, e.fl, e.al, e.ax, e.fo);
            end
        end
    end

    task automatic smp(input int ch, input int v, input int i);
        smp_vld[ch] = 1'b1;
        volt_smp[ch*VW +: VW] = VW'(v);
        curr_smp[ch*IW +: IW] = IW'(i);
    endtask

    // driver: push expectation for the coming edge, then release pulses
    task automatic step(input string tag, input bit chk);
        if (chk) begin
            exp_t e;
            e.due = cyc + 1; e.fl = e_flags; e.al = ~|e_flags;
            e.ax = ~|e_aux; e.fo = ~|e_trip; e.tag = tag;
            q.push_back(e);
        end
        @(posedge clk); #1;
        smp_vld = '0; on_req = '0; clr_faults = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: got hang exp completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            lim_vuf[c*VW +: VW] = 900;  lim_vuw[c*VW +: VW] = 925;
            lim_vow[c*VW +: VW] = 1075; lim_vof[c*VW +: VW] = 1100;
            lim_iuf[c*IW +: IW] = -16'sd100;
            lim_iow[c*IW +: IW] = 400;  lim_iof[c*IW +: IW] = 440;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        step("R1 reset state", 1);

        on_req[0] = 1; step("R8 ch0 start", 1);
        smp(0, 1000, 100); step("R8 ch0 ramp done", 1);
        smp(0, 1080, 100); e_flags[7:0] = 8'h04; step("R2 OV warning", 1);
        clr_faults = 1; step("R5 clear blocked while present", 1);
        smp(0, 1000, 100); step("R4 sticky after condition gone", 1);
        clr_faults = 1; e_flags[7:0] = 8'h00; step("R4 clear releases alert", 1);
        smp(0, 910, 100); e_flags[7:0] = 8'h02; step("R2 UV warning only", 1);
        smp(0, 1000, 100); step("R2 good sample", 0);
        clr_faults = 1; e_flags[7:0] = 8'h00; step("R4 clear", 1);

        smp(0, 1120, 100); e_flags[7:0] = 8'h0C; e_aux[0] = 1; e_trip[0] = 1;
        step("R6 OV fault sets aux and trip", 1);
        clr_faults = 1; e_flags[7:0] = 8'h00; step("R6 aux survives clear", 1);
        on_req[0] = 1; e_aux[0] = 0; e_trip[0] = 0; step("R6 restart releases aux", 1);
        smp(0, 1000, 100); step("R7 ch0 back on", 1);
        smp(0, 1000, 450); e_flags[7:0] = 8'h30; e_aux[0] = 1; e_trip[0] = 1;
        step("R3 OC fault", 1);
        clr_faults = 1; e_flags[7:0] = 8'h00; step("R7 trip survives clear", 1);
        on_req[0] = 1; e_aux[0] = 0; e_trip[0] = 0; step("R7 restart", 0);
        smp(0, 1000, 100); step("R7 ch0 on", 1);

        on_req[1] = 1; step("R3 ch1 start", 0);
        smp(1, 1000, -50); step("R3 small negative current ok", 1);
        smp(1, 1000, -150); e_flags[15:8] = 8'h40; e_aux[1] = 1; e_trip[1] = 1;
        step("R3 UC fault signed", 1);
        smp(1, 1000, 420); step("R9 tripped channel ignores sample", 1);
        clr_faults = 1; e_flags[15:8] = 8'h00; step("R4 clear ch1", 1);
        on_req[1] = 1; e_aux[1] = 0; e_trip[1] = 0; step("R6 ch1 restart", 0);
        smp(1, 1000, 0); step("R3 ch1 on", 1);
        smp(1, 1000, 420); e_flags[15:8] = 8'h10; step("R3 OC warning no aux", 1);
        smp(1, 1000, 0); step("R3 good", 0);
        clr_faults = 1; e_flags[15:8] = 8'h00; step("R4 clear ch1", 1);

        on_req[2] = 1; step("R8 ch2 start", 1);
        smp(2, 500, 0); step("R8 UV masked in ramp", 1);
        for (int k = 0; k < TON - 3; k++) step("idle", 0);
        step("R8 no timeout one edge early", 1);
        e_flags[23:16] = 8'h80; e_trip[2] = 1; step("R8 ramp timeout", 1);
        clr_faults = 1; e_flags[23:16] = 8'h00; step("R7 timeout trip held", 1);

        on_req[3] = 1; step("R7 ch3 start", 0);
        smp(3, 1000, 0); step("R7 ch3 on", 1);
        smp(3, 850, 0); e_flags[31:24] = 8'h03; e_trip[3] = 1;
        step("R2 UV fault trips without aux", 1);
        clr_faults = 1; e_flags[31:24] = 8'h00; step("R5 clear after trip", 1);
        smp(3, 2000, 500); step("R9 sample ignored when tripped", 1);

        step("drain", 0);
        if (q.size() != 0) begin
            n_fail++;
            $display("FAIL R4 scoreboard: got %0d left exp 0", q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule